// File: doc/BRIEF.md
# Two-Channel DMA Register Bank

This block is the software-visible register file for a DMA controller with two channels. A host reaches it over a simple 32-bit read/write bus. The bank keeps each channel's transfer length, source and destination addresses, next-descriptor pointer, control word, priority word, current-descriptor pointer, interrupt mask and interrupt status. The data-moving engine sits outside the bank. It receives level outputs decoded from the control word (run, abort, chaining, interrupt mode, descriptor close, address hold for source and destination) and a one-cycle request to fetch the next descriptor. In return it reports busy, completion events and the descriptor it is working on.

The address space is split into 16-byte groups, one per register kind. Within a group the channels occupy consecutive 32-bit words, so channel n lives at the group base plus 4*n. A completion event sets the channel's status flag. Software clears the flag by writing the status word with bit 0 low. The interrupt outputs follow status gated by mask: one output per channel and one combined output.

Top module: `dual_dma_regbank`

## Requirements
- R1: After reset every readable register of both channels reads 0, and every engine-side and interrupt output is 0.
- R2: Byte count (group 0x00), source address (0x10), destination address (0x20), next descriptor (0x30) and priority (0x60) are full 32-bit read/write registers. Channel n is at group base + 4*n. Each value also appears on that channel's slice of the matching engine output.
- R3: The control word (group 0x40) drives the engine outputs as follows: bit 12 run enable, bit 20 abort, bit 9 chain mode, bit 10 interrupt mode, bit 17 descriptor close. Bits [3:2] give the source address mode and bits [5:4] the destination address mode, where 2'b10 raises the hold output and any other value means increment.
- R4: Writing control bit 13 as 1 raises that channel's fetch output for exactly the cycle after the write. Bit 13 is not stored and always reads 0.
- R5: Control bit 14 reads the engine's busy input for that channel. Writes to bit 14 are ignored.
- R6: Clearing bit 12 drops the run output without changing any other register of the channel. Setting it again raises the run output with all values intact.
- R7: A completion pulse sets status bit 0 (group 0xA0). A write with bit 0 at 0 clears it. A write with bit 0 at 1 leaves it unchanged. Only bit 0 of status and of mask (group 0x80) is stored; the other bits read 0.
- R8: When a completion pulse and a clearing write to the same status bit fall in the same cycle, the bit ends up set.
- R9: Each per-channel interrupt output equals status bit 0 AND mask bit 0 of that channel. The combined output is the OR of the per-channel outputs.
- R10: The current-descriptor register (group 0x70) loads from the engine when its load strobe is high. Bus writes to it are ignored.
- R11: Reads of unmapped groups (such as 0x50), of channel slots 2 and 3, and of addresses with bits [1:0] non-zero return 0. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| eng_busy | input | 2 | Per-channel engine busy |
| eng_done | input | 2 | Per-channel completion pulse |
| eng_cur_load | input | 2 | Per-channel current-descriptor load strobe |
| eng_cur_desc | input | 64 | Current-descriptor values, channel n at [32n+31:32n] |
| ch_enable | output | 2 | Run enable per channel |
| ch_fetch | output | 2 | One-cycle fetch-next-descriptor request |
| ch_abort | output | 2 | Abort level |
| ch_chain | output | 2 | Chain mode |
| ch_irq_mode | output | 2 | Interrupt mode |
| ch_close | output | 2 | Descriptor close enable |
| ch_src_hold | output | 2 | Source address held |
| ch_dst_hold | output | 2 | Destination address held |
| ch_byte_cnt | output | 64 | Byte counts |
| ch_src_addr | output | 64 | Source addresses |
| ch_dst_addr | output | 64 | Destination addresses |
| ch_next_desc | output | 64 | Next-descriptor pointers |
| ch_priority | output | 64 | Priority words |
| irq | output | 1 | Combined interrupt |
| ch_irq | output | 2 | Per-channel interrupt |

## Verification
Two functions can land in the same clock edge and contend for one bit: the engine's completion pulse and a software write that clears the same status flag. The bench provokes this by driving the completion pulse in the very cycle of a zero write to the status word. It judges the result by reading the status back as 1 and seeing the interrupt still asserted. A second overlap puts a fetch-command write next to the run and mode fields in one control write. The bench checks that the pulse lasts one cycle while the stored fields hold, and a behavioural model is compared against every output on every clock.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;

  // register groups: address bits [7:4]
  localparam logic [3:0] GRP_BCNT = 4'h0;
  localparam logic [3:0] GRP_SRC  = 4'h1;
  localparam logic [3:0] GRP_DST  = 4'h2;
  localparam logic [3:0] GRP_NEXT = 4'h3;
  localparam logic [3:0] GRP_CTRL = 4'h4;
  localparam logic [3:0] GRP_PRIO = 4'h6;
  localparam logic [3:0] GRP_CURR = 4'h7;
  localparam logic [3:0] GRP_MASK = 4'h8;
  localparam logic [3:0] GRP_STAT = 4'hA;

  // control word fields
  localparam int BIT_CHAIN = 9;
  localparam int BIT_IMODE = 10;
  localparam int BIT_EN    = 12;
  localparam int BIT_FETCH = 13;
  localparam int BIT_ACT   = 14;
  localparam int BIT_CLOSE = 17;
  localparam int BIT_ABORT = 20;
  localparam int SRC_LSB   = 2;
  localparam int DST_LSB   = 4;
  localparam logic [1:0] MODE_HOLD = 2'b10;

  // bits of the control word that are kept in flops
  localparam logic [31:0] CTRL_KEEP = ~((32'h1 << BIT_FETCH) | (32'h1 << BIT_ACT));

  typedef struct packed {
    logic bcnt;
    logic src;
    logic dst;
    logic nxt;
    logic ctrl;
    logic prio;
  } reg_we_t;

endpackage

// File: rtl/dma_rb_decode.sv
module dma_rb_decode
  import dma_rb_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  output reg_we_t [NCH-1:0]    reg_we,
  output logic    [NCH-1:0]    mask_we,
  output logic    [NCH-1:0]    stat_we,
  output logic    [3:0]        grp,
  output logic    [1:0]        ch,
  output logic                 ch_ok
);
  localparam logic [2:0] NCH_L = 3'(NCH);

  logic wr_ok;

  always_comb begin
    grp   = bus_addr[7:4];
    ch    = bus_addr[3:2];
    ch_ok = ({1'b0, ch} < NCH_L) && (bus_addr[1:0] == 2'b00);
    wr_ok = bus_sel && bus_wr && ch_ok;
    for (int c = 0; c < NCH; c++) begin
      reg_we[c]  = '0;
      mask_we[c] = 1'b0;
      stat_we[c] = 1'b0;
      if (wr_ok && ch == 2'(c)) begin
        case (grp)
          GRP_BCNT: reg_we[c].bcnt = 1'b1;
          GRP_SRC:  reg_we[c].src  = 1'b1;
          GRP_DST:  reg_we[c].dst  = 1'b1;
          GRP_NEXT: reg_we[c].nxt  = 1'b1;
          GRP_CTRL: reg_we[c].ctrl = 1'b1;
          GRP_PRIO: reg_we[c].prio = 1'b1;
          GRP_MASK: mask_we[c]     = 1'b1;
          GRP_STAT: stat_we[c]     = 1'b1;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
  import dma_rb_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  reg_we_t       we,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          cur_load,
  input  logic [DW-1:0] cur_in,
  output logic [DW-1:0] bcnt_q,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] dst_q,
  output logic [DW-1:0] nxt_q,
  output logic [DW-1:0] prio_q,
  output logic [DW-1:0] cur_q,
  output logic [DW-1:0] ctrl_rd,
  output logic          fetch_o,
  output logic          enable_o,
  output logic          abort_o,
  output logic          chain_o,
  output logic          imode_o,
  output logic          close_o,
  output logic          src_hold_o,
  output logic          dst_hold_o
);
  localparam logic [DW-1:0] KEEP = DW'(CTRL_KEEP);

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0] bcnt_d, src_d, dst_d, nxt_d, prio_d, cur_d;
  logic          fetch_d;

  always_comb begin
    bcnt_d  = we.bcnt ? wdata : bcnt_q;
    src_d   = we.src  ? wdata : src_q;
    dst_d   = we.dst  ? wdata : dst_q;
    nxt_d   = we.nxt  ? wdata : nxt_q;
    prio_d  = we.prio ? wdata : prio_q;
    ctrl_d  = we.ctrl ? (wdata & KEEP) : ctrl_q;
    cur_d   = cur_load ? cur_in : cur_q;
    fetch_d = we.ctrl && wdata[BIT_FETCH];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      nxt_q   <= '0;
      prio_q  <= '0;
      ctrl_q  <= '0;
      cur_q   <= '0;
      fetch_o <= 1'b0;
    end else begin
      bcnt_q  <= bcnt_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      nxt_q   <= nxt_d;
      prio_q  <= prio_d;
      ctrl_q  <= ctrl_d;
      cur_q   <= cur_d;
      fetch_o <= fetch_d;
    end
  end

  always_comb begin
    ctrl_rd          = ctrl_q;
    ctrl_rd[BIT_ACT] = busy;
  end

  assign enable_o   = ctrl_q[BIT_EN];
  assign abort_o    = ctrl_q[BIT_ABORT];
  assign chain_o    = ctrl_q[BIT_CHAIN];
  assign imode_o    = ctrl_q[BIT_IMODE];
  assign close_o    = ctrl_q[BIT_CLOSE];
  assign src_hold_o = (ctrl_q[SRC_LSB+1:SRC_LSB] == MODE_HOLD);
  assign dst_hold_o = (ctrl_q[DST_LSB+1:DST_LSB] == MODE_HOLD);

  // R4: a fetch request only follows a control write carrying the command
  assert_fetch_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> $past(we.ctrl && wdata[BIT_FETCH]));

  // R4: the request drops when the command is not repeated
  assert_fetch_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_o && !(we.ctrl && wdata[BIT_FETCH])) |=> !fetch_o);

  // R10: the bus cannot alter the current-descriptor pointer
  assert_cur_engine_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_load |=> $stable(cur_q));

  // R6: run output moves only on a control write
  assert_enable_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we.ctrl |=> $stable(enable_o));

endmodule

// File: rtl/dma_rb_irq.sv
module dma_rb_irq #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] mask_we,
  input  logic [NCH-1:0] stat_we,
  input  logic           wbit0,
  input  logic [NCH-1:0] done,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] stat_q,
  output logic [NCH-1:0] ch_irq,
  output logic           irq
);
  logic [NCH-1:0] mask_d, stat_d, clr;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      clr[c]    = stat_we[c] && !wbit0;
      mask_d[c] = mask_we[c] ? wbit0 : mask_q[c];
      // completion has priority over a clear in the same cycle
      stat_d[c] = (stat_q[c] && !clr[c]) || done[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      mask_q <= mask_d;
      stat_q <= stat_d;
    end
  end

  assign ch_irq = stat_q & mask_q;
  assign irq    = |ch_irq;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R8: a completion pulse always leaves the flag set
    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done[c] |=> stat_q[c]);
    // R7: a zero write without an event clears the flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we[c] && !wbit0 && !done[c]) |=> !stat_q[c]);
    // R7: only an event can raise the flag
    assert_set_by_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[c] && !done[c]) |=> !stat_q[c]);
  end

endmodule

// File: rtl/dual_dma_regbank.sv
module dual_dma_regbank
  import dma_rb_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [7:0]         bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NCH-1:0]     eng_busy,
  input  logic [NCH-1:0]     eng_done,
  input  logic [NCH-1:0]     eng_cur_load,
  input  logic [NCH*DW-1:0]  eng_cur_desc,
  output logic [NCH-1:0]     ch_enable,
  output logic [NCH-1:0]     ch_fetch,
  output logic [NCH-1:0]     ch_abort,
  output logic [NCH-1:0]     ch_chain,
  output logic [NCH-1:0]     ch_irq_mode,
  output logic [NCH-1:0]     ch_close,
  output logic [NCH-1:0]     ch_src_hold,
  output logic [NCH-1:0]     ch_dst_hold,
  output logic [NCH*DW-1:0]  ch_byte_cnt,
  output logic [NCH*DW-1:0]  ch_src_addr,
  output logic [NCH*DW-1:0]  ch_dst_addr,
  output logic [NCH*DW-1:0]  ch_next_desc,
  output logic [NCH*DW-1:0]  ch_priority,
  output logic               irq,
  output logic [NCH-1:0]     ch_irq
);
  localparam int CW = $clog2(NCH);

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  reg_we_t [NCH-1:0] reg_we;
  logic [NCH-1:0]    mask_we, stat_we, mask_q, stat_q;
  logic [3:0]        grp;
  logic [1:0]        ch;
  logic              ch_ok;
  logic [CW-1:0]     chi;

  logic [NCH-1:0][DW-1:0] bcnt_v, src_v, dst_v, nxt_v, prio_v, cur_v, ctrl_v;

  dma_rb_decode #(.NCH(NCH)) u_decode (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .reg_we  (reg_we),
    .mask_we (mask_we),
    .stat_we (stat_we),
    .grp     (grp),
    .ch      (ch),
    .ch_ok   (ch_ok)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_rb_chan #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .we        (reg_we[c]),
      .wdata     (bus_wdata),
      .busy      (eng_busy[c]),
      .cur_load  (eng_cur_load[c]),
      .cur_in    (eng_cur_desc[c*DW +: DW]),
      .bcnt_q    (bcnt_v[c]),
      .src_q     (src_v[c]),
      .dst_q     (dst_v[c]),
      .nxt_q     (nxt_v[c]),
      .prio_q    (prio_v[c]),
      .cur_q     (cur_v[c]),
      .ctrl_rd   (ctrl_v[c]),
      .fetch_o   (ch_fetch[c]),
      .enable_o  (ch_enable[c]),
      .abort_o   (ch_abort[c]),
      .chain_o   (ch_chain[c]),
      .imode_o   (ch_irq_mode[c]),
      .close_o   (ch_close[c]),
      .src_hold_o(ch_src_hold[c]),
      .dst_hold_o(ch_dst_hold[c])
    );
  end

  dma_rb_irq #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .mask_we(mask_we),
    .stat_we(stat_we),
    .wbit0  (bus_wdata[0]),
    .done   (eng_done),
    .mask_q (mask_q),
    .stat_q (stat_q),
    .ch_irq (ch_irq),
    .irq    (irq)
  );

  assign ch_byte_cnt  = bcnt_v;
  assign ch_src_addr  = src_v;
  assign ch_dst_addr  = dst_v;
  assign ch_next_desc = nxt_v;
  assign ch_priority  = prio_v;

  assign chi = ch[CW-1:0];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && ch_ok) begin
      case (grp)
        GRP_BCNT: bus_rdata = bcnt_v[chi];
        GRP_SRC:  bus_rdata = src_v[chi];
        GRP_DST:  bus_rdata = dst_v[chi];
        GRP_NEXT: bus_rdata = nxt_v[chi];
        GRP_CTRL: bus_rdata = ctrl_v[chi];
        GRP_PRIO: bus_rdata = prio_v[chi];
        GRP_CURR: bus_rdata = cur_v[chi];
        GRP_MASK: bus_rdata = DW'(mask_q[chi]);
        GRP_STAT: bus_rdata = DW'(stat_q[chi]);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R11: out-of-range or misaligned reads return zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_sel && !bus_wr && !ch_ok) |-> (bus_rdata == '0));

  // R5: the active bit mirrors the engine busy line
  assert_active_view_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_sel && !bus_wr && ch_ok && grp == GRP_CTRL) |-> (bus_rdata[BIT_ACT] == eng_busy[chi]));

  // R4: a fetch request is never issued to a channel twice without a new command
  assert_fetch_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    !(bus_sel && bus_wr) |=> (ch_fetch == '0));

endmodule

// File: tb/dual_dma_regbank_bench.sv
`timescale 1ns/1ps
module dual_dma_regbank_bench;
  localparam int NCH = 2;
  localparam int DW  = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              bus_sel, bus_wr;
  logic [7:0]        bus_addr;
  logic [DW-1:0]     bus_wdata, bus_rdata;
  logic [NCH-1:0]    eng_busy, eng_done, eng_cur_load;
  logic [NCH*DW-1:0] eng_cur_desc;
  logic [NCH-1:0]    ch_enable, ch_fetch, ch_abort, ch_chain, ch_irq_mode, ch_close;
  logic [NCH-1:0]    ch_src_hold, ch_dst_hold, ch_irq;
  logic [NCH*DW-1:0] ch_byte_cnt, ch_src_addr, ch_dst_addr, ch_next_desc, ch_priority;
  logic              irq;

  dual_dma_regbank #(.NCH(NCH), .DW(DW)) u_dual_dma_regbank (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_cur_load(eng_cur_load),
    .eng_cur_desc(eng_cur_desc), .ch_enable(ch_enable), .ch_fetch(ch_fetch),
    .ch_abort(ch_abort), .ch_chain(ch_chain), .ch_irq_mode(ch_irq_mode),
    .ch_close(ch_close), .ch_src_hold(ch_src_hold), .ch_dst_hold(ch_dst_hold),
    .ch_byte_cnt(ch_byte_cnt), .ch_src_addr(ch_src_addr), .ch_dst_addr(ch_dst_addr),
    .ch_next_desc(ch_next_desc), .ch_priority(ch_priority), .irq(irq), .ch_irq(ch_irq)
  );

  int tests = 0;
  int fails = 0;
  logic cmp_on = 1'b0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] m_bc [NCH];
  logic [DW-1:0] m_sa [NCH];
  logic [DW-1:0] m_da [NCH];
  logic [DW-1:0] m_nd [NCH];
  logic [DW-1:0] m_pr [NCH];
  logic [DW-1:0] m_ct [NCH];
  logic [DW-1:0] m_cu [NCH];
  logic          m_mk [NCH];
  logic          m_st [NCH];
  logic          m_fe [NCH];

  function automatic logic hitw(int c, logic [3:0] g);
    return bus_sel && bus_wr && bus_addr[1:0] == 2'b00 &&
           int'(bus_addr[3:2]) == c && bus_addr[7:4] == g;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_bc[c] <= '0; m_sa[c] <= '0; m_da[c] <= '0; m_nd[c] <= '0;
        m_pr[c] <= '0; m_ct[c] <= '0; m_cu[c] <= '0;
        m_mk[c] <= 1'b0; m_st[c] <= 1'b0; m_fe[c] <= 1'b0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (hitw(c, 4'h0)) m_bc[c] <= bus_wdata;
        if (hitw(c, 4'h1)) m_sa[c] <= bus_wdata;
        if (hitw(c, 4'h2)) m_da[c] <= bus_wdata;
        if (hitw(c, 4'h3)) m_nd[c] <= bus_wdata;
        if (hitw(c, 4'h4)) m_ct[c] <= bus_wdata & ~32'h0000_6000;
        if (hitw(c, 4'h6)) m_pr[c] <= bus_wdata;
        if (hitw(c, 4'h8)) m_mk[c] <= bus_wdata[0];
        m_fe[c] <= hitw(c, 4'h4) && bus_wdata[13];
        m_st[c] <= (m_st[c] && !(hitw(c, 4'hA) && !bus_wdata[0])) || eng_done[c];
        if (eng_cur_load[c]) m_cu[c] <= eng_cur_desc[c*DW +: DW];
      end
    end
  end

  function automatic logic [DW-1:0] mread(logic [7:0] a);
    int c;
    logic [DW-1:0] r;
    c = int'(a[3:2]);
    if (c >= NCH || a[1:0] != 2'b00) return '0;
    case (a[7:4])
      4'h0: r = m_bc[c];
      4'h1: r = m_sa[c];
      4'h2: r = m_da[c];
      4'h3: r = m_nd[c];
      4'h4: begin r = m_ct[c]; r[14] = eng_busy[c]; end
      4'h6: r = m_pr[c];
      4'h7: r = m_cu[c];
      4'h8: r = DW'(m_mk[c]);
      4'hA: r = DW'(m_st[c]);
      default: r = '0;
    endcase
    return r;
  endfunction

  // per-clock comparison of every engine-side and interrupt output
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NCH-1:0] e_en, e_fe, e_ab, e_chn, e_im, e_cl, e_sh, e_dh, e_ci;
      logic [NCH*DW-1:0] e_bc, e_sa, e_da, e_nd, e_pr;
      for (int c = 0; c < NCH; c++) begin
        e_en[c]  = m_ct[c][12];
        e_ab[c]  = m_ct[c][20];
        e_chn[c] = m_ct[c][9];
        e_im[c]  = m_ct[c][10];
        e_cl[c]  = m_ct[c][17];
        e_sh[c]  = (m_ct[c][3:2] == 2'b10);
        e_dh[c]  = (m_ct[c][5:4] == 2'b10);
        e_fe[c]  = m_fe[c];
        e_ci[c]  = m_st[c] && m_mk[c];
        e_bc[c*DW +: DW] = m_bc[c];
        e_sa[c*DW +: DW] = m_sa[c];
        e_da[c*DW +: DW] = m_da[c];
        e_nd[c*DW +: DW] = m_nd[c];
        e_pr[c*DW +: DW] = m_pr[c];
      end
      chk("R3 control decode",
          64'({ch_enable, ch_abort, ch_chain, ch_irq_mode, ch_close, ch_src_hold, ch_dst_hold}),
          64'({e_en, e_ab, e_chn, e_im, e_cl, e_sh, e_dh}));
      chk("R4 fetch pulse", 64'(ch_fetch), 64'(e_fe));
      chk("R9 interrupt outputs", 64'({irq, ch_irq}), 64'({|e_ci, e_ci}));
      chk("R2 byte count out", ch_byte_cnt, e_bc);
      chk("R2 source out", ch_src_addr, e_sa);
      chk("R2 destination out", ch_dst_addr, e_da);
      chk("R2 next descriptor out", ch_next_desc, e_nd);
      chk("R2 priority out", ch_priority, e_pr);
    end
  end

  task automatic wr(logic [7:0] a, logic [DW-1:0] d);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_model(string tag, logic [7:0] a);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    chk(tag, 64'(bus_rdata), 64'(mread(a)));
    bus_sel = 1'b0;
  endtask

  task automatic rd_lit(string tag, logic [7:0] a, logic [DW-1:0] exp);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    chk(tag, 64'(bus_rdata), 64'(exp));
    bus_sel = 1'b0;
  endtask

  task automatic done_pulse(logic [NCH-1:0] d);
    @(negedge clk); #1;
    eng_done = d;
    @(posedge clk); #1;
    eng_done = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  localparam logic [31:0] CT0 = (32'h1 << 12) | (32'h1 << 9) | (32'h1 << 20) |
                                (32'h1 << 17) | (32'h1 << 10) | (32'h2 << 4);
  localparam logic [31:0] CT1 = (32'h1 << 12) | (32'h2 << 2);

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_busy = '0; eng_done = '0; eng_cur_load = '0; eng_cur_desc = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cmp_on = 1'b1;

    // R1: reset values
    for (int c = 0; c < NCH; c++) begin
      rd_lit("R1 byte count reset", {4'h0, 2'(c), 2'b00}, '0);
      rd_lit("R1 control reset",    {4'h4, 2'(c), 2'b00}, '0);
      rd_lit("R1 current reset",    {4'h7, 2'(c), 2'b00}, '0);
      rd_lit("R1 mask reset",       {4'h8, 2'(c), 2'b00}, '0);
      rd_lit("R1 status reset",     {4'hA, 2'(c), 2'b00}, '0);
    end
    chk("R1 outputs after reset", 64'({ch_enable, ch_fetch, irq, ch_irq}), 64'd0);

    // R2: read/write registers with channel interleave
    for (int c = 0; c < NCH; c++) begin
      for (int g = 0; g < 7; g++) begin
        if (g != 4 && g != 5)
          wr({4'(g), 2'(c), 2'b00}, 32'hA500_0000 ^ (32'(g) << 8) ^ (32'(c) * 32'h11));
      end
    end
    for (int c = 0; c < NCH; c++) begin
      for (int g = 0; g < 7; g++) begin
        if (g != 4 && g != 5) rd_model("R2 register read-back", {4'(g), 2'(c), 2'b00});
      end
    end
    wr(8'h14, 32'hDEAD_BEEF);
    rd_lit("R2 channel 1 source at 0x14", 8'h14, 32'hDEAD_BEEF);
    rd_lit("R2 channel 0 source untouched", 8'h10, 32'hA500_0100);

    // R3: control decode
    wr(8'h40, CT0);
    wr(8'h44, CT1);
    rd_lit("R3 control read-back ch0", 8'h40, CT0);
    @(negedge clk);
    chk("R3 hold outputs", 64'({ch_src_hold, ch_dst_hold}), 64'({2'b10, 2'b01}));

    // R4: fetch command pulse
    wr(8'h44, CT1 | (32'h1 << 13));
    @(negedge clk);
    chk("R4 fetch pulse raised", 64'(ch_fetch), 64'(2'b10));
    @(negedge clk);
    chk("R4 fetch pulse dropped", 64'(ch_fetch), 64'd0);
    rd_lit("R4 fetch bit reads zero", 8'h44, CT1);

    // R5: active bit
    @(negedge clk); #1 eng_busy = 2'b01;
    rd_lit("R5 active reflects busy", 8'h40, CT0 | (32'h1 << 14));
    wr(8'h44, CT1 | (32'h1 << 14));
    rd_lit("R5 active write ignored", 8'h44, CT1);
    @(negedge clk); #1 eng_busy = 2'b00;

    // R6: pause and resume
    wr(8'h40, CT0 & ~(32'h1 << 12));
    @(negedge clk);
    chk("R6 paused", 64'(ch_enable), 64'(2'b10));
    rd_model("R6 byte count kept", 8'h00);
    rd_model("R6 next descriptor kept", 8'h30);
    wr(8'h40, CT0);
    @(negedge clk);
    chk("R6 resumed", 64'(ch_enable), 64'(2'b11));

    // R10: current descriptor
    @(negedge clk); #1 eng_cur_load = 2'b01; eng_cur_desc = {32'h0, 32'h1234_5670};
    @(posedge clk); #1 eng_cur_load = 2'b00;
    rd_lit("R10 current loaded", 8'h70, 32'h1234_5670);
    wr(8'h70, 32'hFFFF_FFFF);
    rd_lit("R10 bus write ignored", 8'h70, 32'h1234_5670);
    rd_lit("R10 other channel untouched", 8'h74, '0);

    // R7 / R9: status and mask
    wr(8'h80, 32'h1);
    wr(8'h84, 32'h0);
    done_pulse(2'b01);
    @(negedge clk);
    chk("R9 irq on masked-in event", 64'({irq, ch_irq}), 64'({1'b1, 2'b01}));
    wr(8'hA0, 32'h1);
    rd_lit("R7 write one keeps flag", 8'hA0, 32'h1);
    wr(8'hA0, 32'hFFFF_FFFE);
    rd_lit("R7 write zero clears flag", 8'hA0, 32'h0);
    wr(8'hA4, 32'h1);
    rd_lit("R7 write one does not set", 8'hA4, 32'h0);
    done_pulse(2'b10);
    rd_lit("R7 event sets ch1 flag", 8'hA4, 32'h1);
    @(negedge clk);
    chk("R9 masked-out channel quiet", 64'({irq, ch_irq}), 64'd0);
    wr(8'h80, 32'hFFFF_FFFF);
    rd_lit("R7 mask keeps bit 0 only", 8'h80, 32'h1);

    // R8: event and clear in the same cycle
    done_pulse(2'b01);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'hA0; bus_wdata = 32'h0; eng_done = 2'b01;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; eng_done = 2'b00;
    rd_lit("R8 event wins over clear", 8'hA0, 32'h1);
    @(negedge clk);
    chk("R8 irq held", 64'(irq), 64'd1);
    wr(8'hA0, 32'h0);
    rd_lit("R8 later clear works", 8'hA0, 32'h0);

    // R11: unmapped accesses
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h48, 32'h0000_1000);
    wr(8'h42, 32'h0);
    rd_lit("R11 group 0x50 reads zero", 8'h50, '0);
    rd_lit("R11 channel slot 2 reads zero", 8'h48, '0);
    rd_lit("R11 channel slot 3 reads zero", 8'h4C, '0);
    rd_lit("R11 misaligned reads zero", 8'h41, '0);
    rd_lit("R11 control ch0 unchanged", 8'h40, CT0);
    rd_model("R11 control ch1 unchanged", 8'h44);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule